// File: doc/BRIEF.md
# Memory Power-Up Initialization Sequencer

This block sits on the controller side of a graphics-class DDR memory device and runs the device's power-up sequence after power and clocks are stable. A start strobe sets it going. It holds the device reset pin low with chip select high. During that time it drives CKE to a strap value, so the device latches that value at the reset rising edge. The strap picks the address/command termination strength: low gives half of the calibration resistor value and high gives the full value. The block then raises CKE and waits with DESELECT on the bus. After that it issues a fixed list of commands.

The command list is: precharge all banks, load the extended mode register, load the main mode register with the DLL-reset bit set, precharge all banks again, and two auto refreshes. Each command is followed by its own programmable gap. The block raises a ready flag once the second refresh's gap has passed and the DLL lock window, counted from the DLL reset, has expired. Normal traffic may start after that. All delay counts are in clock cycles and must stay stable while a sequence runs. The two mode-register opcodes come in as ports.

Top module: `meminit_seq`

## Requirements
- R1: During and after synchronous reset the outputs are: mem_rst_n=0, mem_cke=0, chip select and all command pins high, mem_ba=0, mem_addr=0, ready=0.
- R2: After an accepted start, mem_rst_n stays low for max(dly_rst_low,1) cycles and then goes high. During those cycles mem_cke carries the value term_strap had when start was accepted.
- R3: From the cycle mem_rst_n rises, mem_cke keeps the strap value for max(dly_cke_hold,1) cycles. It then stays high until abort or reset, and it does not change in the cycle the reset pin rises.
- R4: After the CKE hold, the bus carries DESELECT for max(dly_settle,1) cycles before the first command.
- R5: Commands are issued in this order: PRECHARGE ALL, LOAD MODE (extended), LOAD MODE (main), PRECHARGE ALL, AUTO REFRESH, AUTO REFRESH. The encodings on {cs_n,ras_n,cas_n,we_n} are: PRECHARGE 0010, LOAD MODE 0000, AUTO REFRESH 0001, DESELECT 1111. Every cycle without a command is DESELECT.
- R6: Address and bank values are as follows. PRECHARGE ALL: mem_addr bit 8 set, all other bits 0, mem_ba=0. Extended load: mem_ba=3'b001 (bank bit 0 high, bank bit 1 low), mem_addr=emr_code. Main load: mem_ba=0, mem_addr=mr_code with bit 8 (DLL reset) forced to 1. AUTO REFRESH and DESELECT: mem_ba=0, mem_addr=0.
- R7: The next command follows a PRECHARGE ALL after max(dly_trp,1) cycles, a LOAD MODE after max(dly_tmrd,1) cycles, and an AUTO REFRESH after max(dly_trfc,1) cycles.
- R8: Let p be the main-load cycle and q the first cycle after the second refresh's gap. ready first rises at cycle max(q, p+DLL_LOCK_CYC)+1 (default DLL_LOCK_CYC=5000). It stays high until abort or reset, and chip select stays high while it is high.
- R9: start is ignored unless the block is idle, both during a sequence and after ready.
- R10: abort returns the block to the R1 idle state in the next cycle from any state. It takes priority over start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the sequence (idle only) |
| abort | input | 1 | Synchronous return to idle |
| term_strap | input | 1 | Termination strength strap driven on CKE at reset release |
| dly_rst_low | input | CW | Cycles reset pin is held low |
| dly_cke_hold | input | CW | Cycles CKE holds the strap after reset rises |
| dly_settle | input | CW | DESELECT cycles before the first command |
| dly_trp | input | CW | Gap after PRECHARGE ALL |
| dly_tmrd | input | CW | Gap after LOAD MODE |
| dly_trfc | input | CW | Gap after AUTO REFRESH |
| emr_code | input | AW | Extended mode register opcode |
| mr_code | input | AW | Main mode register opcode |
| mem_rst_n | output | 1 | Device reset pin |
| mem_cke | output | 1 | Device clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BW | Bank address |
| mem_addr | output | AW | Address / opcode bus |
| ready | output | 1 | Initialization complete |

## Verification
The checker enforces several rules on every cycle: no command is issued while the reset pin is low or CKE is low, CKE stays steady across the reset rising edge, the reset pin falls only after an abort, ready is sticky and only seen with DESELECT, every precharge carries bit 8, and every mode load targets bank 0 or 1. Only the bench's cycle model can show the exact position of each command, the gap lengths, the latched strap value, the ready cycle set by whichever of the DLL window or the refresh gap ends later, and that start pulses in the middle of a run leave the timeline unchanged.

// File: rtl/meminit_pkg.sv
package meminit_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RSTLO,
        PH_CKEHOLD,
        PH_SETTLE,
        PH_CMD,
        PH_FIN,
        PH_DONE
    } phase_e;

    typedef enum logic [1:0] {
        OP_PREA,
        OP_LMR_EXT,
        OP_LMR_MAIN,
        OP_REF
    } op_e;

    typedef enum logic [1:0] {
        GAP_RP,
        GAP_MRD,
        GAP_RFC
    } gap_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam int        STEP_W    = 3;
    localparam int        LAST_STEP = 5;
    localparam int        AP_BIT    = 8;
    localparam cmd_pins_t PINS_DESEL = 4'b1111;

    function automatic op_e step_op(input logic [STEP_W-1:0] s);
        case (s)
            3'd0:    return OP_PREA;
            3'd1:    return OP_LMR_EXT;
            3'd2:    return OP_LMR_MAIN;
            3'd3:    return OP_PREA;
            default: return OP_REF;
        endcase
    endfunction

    function automatic cmd_pins_t op_pins(input op_e o);
        case (o)
            OP_PREA: return 4'b0010;
            OP_REF:  return 4'b0001;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic gap_e op_gap(input op_e o);
        case (o)
            OP_PREA: return GAP_RP;
            OP_REF:  return GAP_RFC;
            default: return GAP_MRD;
        endcase
    endfunction

endpackage

// File: rtl/meminit_phase_timer.sv
module meminit_phase_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last,
    output logic          first
);
    logic [CW-1:0] cnt;
    logic          fst;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            fst <= 1'b0;
        end else if (load) begin
            cnt <= load_val;
            fst <= 1'b1;
        end else begin
            fst <= 1'b0;
            if (cnt > CW'(1)) cnt <= cnt - CW'(1);
        end
    end

    assign last  = (cnt <= CW'(1));
    assign first = fst;
endmodule

// File: rtl/meminit_dll_timer.sv
module meminit_dll_timer #(
    parameter int LOCK_CYC = 5000
) (
    input  logic clk,
    input  logic clear,
    input  logic arm,
    output logic done
);
    localparam int DW = $clog2(LOCK_CYC + 1);

    logic [DW-1:0] cnt;
    logic          armed;

    always_ff @(posedge clk) begin
        if (clear) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (arm) begin
            cnt   <= DW'(LOCK_CYC - 1);
            armed <= 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - DW'(1);
        end
    end

    assign done = armed && (cnt == '0);
endmodule

// File: rtl/meminit_step_decode.sv
module meminit_step_decode
    import meminit_pkg::*;
#(
    parameter int AW = 12,
    parameter int BW = 3
) (
    input  logic [STEP_W-1:0] step,
    input  logic [AW-1:0]     emr_code,
    input  logic [AW-1:0]     mr_code,
    output cmd_pins_t         pins,
    output logic [BW-1:0]     ba,
    output logic [AW-1:0]     addr,
    output logic              dll_reset
);
    op_e op;

    always_comb begin
        op        = step_op(step);
        pins      = op_pins(op);
        ba        = '0;
        addr      = '0;
        dll_reset = 1'b0;
        case (op)
            OP_PREA:     addr[AP_BIT] = 1'b1;
            OP_LMR_EXT: begin
                ba   = BW'(1);
                addr = emr_code;
            end
            OP_LMR_MAIN: begin
                addr         = mr_code;
                addr[AP_BIT] = 1'b1;
                dll_reset    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/meminit_seq.sv
module meminit_seq
    import meminit_pkg::*;
#(
    parameter int CW           = 16,
    parameter int AW           = 12,
    parameter int BW           = 3,
    parameter int DLL_LOCK_CYC = 5000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          abort,
    input  logic          term_strap,
    input  logic [CW-1:0] dly_rst_low,
    input  logic [CW-1:0] dly_cke_hold,
    input  logic [CW-1:0] dly_settle,
    input  logic [CW-1:0] dly_trp,
    input  logic [CW-1:0] dly_tmrd,
    input  logic [CW-1:0] dly_trfc,
    input  logic [AW-1:0] emr_code,
    input  logic [AW-1:0] mr_code,
    output logic          mem_rst_n,
    output logic          mem_cke,
    output logic          mem_cs_n,
    output logic          mem_ras_n,
    output logic          mem_cas_n,
    output logic          mem_we_n,
    output logic [BW-1:0] mem_ba,
    output logic [AW-1:0] mem_addr,
    output logic          ready
);
    phase_e            st, st_nxt;
    logic [STEP_W-1:0] step, step_nxt;
    logic              strap_q;
    logic              ld;
    logic [CW-1:0]     ld_val;
    logic              t_last, t_first;
    logic              dll_done;
    logic              issuing;
    cmd_pins_t         dec_pins;
    logic [BW-1:0]     dec_ba;
    logic [AW-1:0]     dec_addr;
    logic              dec_dll;

    function automatic logic [CW-1:0] gap_val(input gap_e g,
                                              input logic [CW-1:0] rp,
                                              input logic [CW-1:0] mrd,
                                              input logic [CW-1:0] rfc);
        case (g)
            GAP_RP:  return rp;
            GAP_RFC: return rfc;
            default: return mrd;
        endcase
    endfunction

    always_comb begin
        st_nxt   = st;
        step_nxt = step;
        ld       = 1'b0;
        ld_val   = '0;
        case (st)
            PH_IDLE: if (start) begin
                st_nxt = PH_RSTLO;
                ld     = 1'b1;
                ld_val = dly_rst_low;
            end
            PH_RSTLO: if (t_last) begin
                st_nxt = PH_CKEHOLD;
                ld     = 1'b1;
                ld_val = dly_cke_hold;
            end
            PH_CKEHOLD: if (t_last) begin
                st_nxt = PH_SETTLE;
                ld     = 1'b1;
                ld_val = dly_settle;
            end
            PH_SETTLE: if (t_last) begin
                st_nxt   = PH_CMD;
                step_nxt = '0;
                ld       = 1'b1;
                ld_val   = gap_val(op_gap(step_op('0)), dly_trp, dly_tmrd, dly_trfc);
            end
            PH_CMD: if (t_last) begin
                if (step == STEP_W'(LAST_STEP)) begin
                    st_nxt = PH_FIN;
                end else begin
                    step_nxt = step + STEP_W'(1);
                    ld       = 1'b1;
                    ld_val   = gap_val(op_gap(step_op(step + STEP_W'(1))),
                                       dly_trp, dly_tmrd, dly_trfc);
                end
            end
            PH_FIN: if (dll_done) st_nxt = PH_DONE;
            default: ;
        endcase
        if (abort) begin
            st_nxt = PH_IDLE;
            ld     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= PH_IDLE;
            step    <= '0;
            strap_q <= 1'b0;
        end else begin
            st   <= st_nxt;
            step <= step_nxt;
            if (st == PH_IDLE && start && !abort) strap_q <= term_strap;
        end
    end

    meminit_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .last     (t_last),
        .first    (t_first)
    );

    meminit_step_decode #(.AW(AW), .BW(BW)) u_dec (
        .step      (step),
        .emr_code  (emr_code),
        .mr_code   (mr_code),
        .pins      (dec_pins),
        .ba        (dec_ba),
        .addr      (dec_addr),
        .dll_reset (dec_dll)
    );

    assign issuing = (st == PH_CMD) && t_first;

    meminit_dll_timer #(.LOCK_CYC(DLL_LOCK_CYC)) u_dll (
        .clk   (clk),
        .clear (rst || abort),
        .arm   (issuing && dec_dll),
        .done  (dll_done)
    );

    always_comb begin
        mem_rst_n = !(st == PH_IDLE || st == PH_RSTLO);
        case (st)
            PH_IDLE:               mem_cke = 1'b0;
            PH_RSTLO, PH_CKEHOLD:  mem_cke = strap_q;
            default:               mem_cke = 1'b1;
        endcase
        {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = issuing ? dec_pins : PINS_DESEL;
        mem_ba   = issuing ? dec_ba   : '0;
        mem_addr = issuing ? dec_addr : '0;
        ready    = (st == PH_DONE);
    end
endmodule

// File: rtl/meminit_seq_chk.sv
module meminit_seq_chk #(
    parameter int BW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          abort,
    input logic          mem_rst_n,
    input logic          mem_cke,
    input logic          mem_cs_n,
    input logic          mem_ras_n,
    input logic          mem_cas_n,
    input logic          mem_we_n,
    input logic [BW-1:0] mem_ba,
    input logic          mem_ap,
    input logic          ready
);
    logic [3:0] pins;
    assign pins = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};

    AST_CMD_NEEDS_RST_HIGH: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n |-> (mem_rst_n && mem_cke)); // R5

    AST_CKE_STABLE_AT_RST_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_rst_n) |-> $stable(mem_cke)); // R3

    AST_RST_FALL_ONLY_ABORT: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_rst_n) |-> $past(abort)); // R10

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!mem_rst_n && !mem_cke && mem_cs_n && !ready)); // R10

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ready && !abort) |=> ready); // R8

    AST_READY_DESELECT: assert property (@(posedge clk) disable iff (rst)
        ready |-> (mem_cs_n && mem_rst_n && mem_cke)); // R8

    AST_PREA_AP_BIT: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0010) |-> mem_ap); // R6

    AST_LMR_BANK: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0000) |-> (mem_ba == BW'(0) || mem_ba == BW'(1))); // R6
endmodule

bind meminit_seq meminit_seq_chk #(.BW(BW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .abort     (abort),
    .mem_rst_n (mem_rst_n),
    .mem_cke   (mem_cke),
    .mem_cs_n  (mem_cs_n),
    .mem_ras_n (mem_ras_n),
    .mem_cas_n (mem_cas_n),
    .mem_we_n  (mem_we_n),
    .mem_ba    (mem_ba),
    .mem_ap    (mem_addr[8]),
    .ready     (ready)
);

// File: tb/meminit_seq_tb.sv
module meminit_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW  = 16;
    localparam int AW  = 12;
    localparam int BW  = 3;
    localparam int DLL = 100;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, abort = 1'b0, term_strap = 1'b0;
    logic [CW-1:0] dly_rst_low = 5, dly_cke_hold = 3, dly_settle = 4;
    logic [CW-1:0] dly_trp = 3, dly_tmrd = 2, dly_trfc = 6;
    logic [AW-1:0] emr_code = 12'h0A5, mr_code = 12'h0C3;
    logic mem_rst_n, mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, ready;
    logic [BW-1:0] mem_ba;
    logic [AW-1:0] mem_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    meminit_seq #(.CW(CW), .AW(AW), .BW(BW), .DLL_LOCK_CYC(DLL)) u_dut (
        .clk(clk), .rst(rst), .start(start), .abort(abort), .term_strap(term_strap),
        .dly_rst_low(dly_rst_low), .dly_cke_hold(dly_cke_hold), .dly_settle(dly_settle),
        .dly_trp(dly_trp), .dly_tmrd(dly_tmrd), .dly_trfc(dly_trfc),
        .emr_code(emr_code), .mr_code(mr_code),
        .mem_rst_n(mem_rst_n), .mem_cke(mem_cke), .mem_cs_n(mem_cs_n),
        .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
        .mem_ba(mem_ba), .mem_addr(mem_addr), .ready(ready)
    );

    int checks = 0, errors = 0, cyc = 0;
    string scen = "R1 reset";
    int mode = 0;           // 0 idle, 1 sequence, 2 done
    bit seen_edge = 0;
    logic [21:0] q[$];
    logic [21:0] exp_v;

    function automatic logic [21:0] mk(bit rn, bit ck, logic [3:0] c, logic [2:0] b,
                                       logic [11:0] a, bit r);
        return {rn, ck, c, b, a, r};
    endfunction

    function automatic int mx1(int v);
        return (v < 1) ? 1 : v;
    endfunction

    localparam logic [21:0] IDLE_V = {1'b0, 1'b0, 4'b1111, 3'd0, 12'd0, 1'b0};
    localparam logic [21:0] DONE_V = {1'b1, 1'b1, 4'b1111, 3'd0, 12'd0, 1'b1};

    task automatic build(bit strap);
        int pos = 0, p = 0, qq, fin;
        for (int i = 0; i < mx1(dly_rst_low); i++) begin q.push_back(mk(0, strap, 4'hF, 0, 0, 0)); pos++; end
        for (int i = 0; i < mx1(dly_cke_hold); i++) begin q.push_back(mk(1, strap, 4'hF, 0, 0, 0)); pos++; end
        for (int i = 0; i < mx1(dly_settle); i++) begin q.push_back(mk(1, 1, 4'hF, 0, 0, 0)); pos++; end
        for (int s = 0; s < 6; s++) begin
            logic [3:0] c; logic [2:0] b; logic [11:0] a; int w;
            case (s)
                0, 3: begin c = 4'b0010; b = 0; a = 12'h100; w = mx1(dly_trp); end
                1:    begin c = 4'b0000; b = 3'b001; a = emr_code; w = mx1(dly_tmrd); end
                2:    begin c = 4'b0000; b = 0; a = mr_code | 12'h100; w = mx1(dly_tmrd); p = pos; end
                default: begin c = 4'b0001; b = 0; a = 0; w = mx1(dly_trfc); end
            endcase
            q.push_back(mk(1, 1, c, b, a, 0)); pos++;
            for (int i = 1; i < w; i++) begin q.push_back(mk(1, 1, 4'hF, 0, 0, 0)); pos++; end
        end
        qq  = pos;
        fin = ((qq > p + DLL) ? qq : p + DLL) - qq + 1;
        for (int i = 0; i < fin; i++) q.push_back(mk(1, 1, 4'hF, 0, 0, 0));
    endtask

    // Reference model: advances on every rising edge from the inputs applied before it.
    always @(posedge clk) begin
        cyc++;
        seen_edge = 1;
        if (rst || abort) begin
            q.delete(); mode = 0; exp_v = IDLE_V;
        end else if (mode == 0) begin
            if (start) begin build(term_strap); exp_v = q.pop_front(); mode = 1; end
            else exp_v = IDLE_V;
        end else if (mode == 1) begin
            if (q.size() > 0) exp_v = q.pop_front();
            else begin mode = 2; exp_v = DONE_V; end
        end else exp_v = DONE_V;
        if (cyc > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s): actual %0h expected %0h", tag, scen, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (seen_edge) begin
            chk("R2 reset pin", 16'(mem_rst_n), 16'(exp_v[21]));
            chk("R3 cke", 16'(mem_cke), 16'(exp_v[20]));
            chk("R5 command pins", 16'({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}), 16'(exp_v[19:16]));
            chk("R6 bank/address", 16'({mem_ba, mem_addr}), 16'(exp_v[15:1]));
            chk("R8 ready", 16'(ready), 16'(exp_v[0]));
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1; tick(1); start = 0;
    endtask

    task automatic wait_ready(int lim);
        for (int i = 0; i < lim && !ready; i++) @(negedge clk);
        tick(3);
    endtask

    initial begin
        tick(3);
        rst = 0;
        tick(4);   // R1 idle outputs compared every cycle

        scen = "R2 R4 R7 strap low, DLL window ends last";
        term_strap = 0;
        pulse_start();
        wait_ready(2000);
        scen = "R9 start after ready ignored";
        pulse_start();
        tick(10);

        scen = "R10 abort from ready";
        abort = 1; tick(1); abort = 0; tick(3);

        scen = "R3 R8 strap high, minimum gaps, refresh gap ends last";
        term_strap = 1;
        dly_rst_low = 0; dly_cke_hold = 0; dly_settle = 1;
        dly_trp = 1; dly_tmrd = 0; dly_trfc = 90;
        emr_code = 12'hFFF; mr_code = 12'h000;
        pulse_start();
        term_strap = 0;   // strap change after start must not matter
        wait_ready(2000);

        abort = 1; tick(1); abort = 0; tick(2);
        scen = "R9 start pulses during sequence ignored";
        dly_rst_low = 8; dly_cke_hold = 2; dly_settle = 3;
        dly_trp = 4; dly_tmrd = 5; dly_trfc = 7;
        emr_code = 12'h321; mr_code = 12'h4BC;
        term_strap = 1;
        pulse_start();
        tick(5); pulse_start(); tick(12); pulse_start(); tick(6);
        scen = "R10 abort mid-sequence";
        abort = 1; tick(1); abort = 0; tick(4);

        scen = "R10 abort wins over start";
        abort = 1; start = 1; tick(1); abort = 0; start = 0; tick(4);

        scen = "R5 R6 full run after abort";
        pulse_start();
        wait_ready(2000);

        scen = "R1 synchronous reset from ready";
        rst = 1; tick(2); rst = 0; tick(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule